// File: doc/BRIEF.md
# Three-Input Integer Add Unit

This execution unit performs one three-operand integer addition per issued instruction. It receives a 64-bit instruction word and three 32-bit operands. Operand A comes from a register file read port whose index the unit decodes and drives back. Operands B and C arrive already fetched. Each operand can be narrowed to one of its 16-bit halves and can be negated. The sum of A and B can be shifted by 16 in either direction before C is added.

The result, its destination register index and a write enable are registered. They appear with a valid pulse one clock after the issue strobe. Two encoding bits that request condition-code output or extended-precision carry are not supported. When either is set, the unit flags the instruction and suppresses the register write.

Top module: `tri_add_unit`

## Requirements
- R1: The destination index output carries instruction bits [7:0] of the issued word. The operand A read index output is instruction bits [15:8], decoded combinationally from the current word.
- R2: Each operand has a 2-bit half field: A at bits [36:35], B at [34:33] and C at [32:31]. Code 0 keeps the whole 32-bit operand. Code 1 keeps bits [15:0] with zero extension. Code 2 keeps bits [31:16] with zero extension.
- R3: Bit 51 negates A, bit 50 negates B and bit 49 negates C. A negated operand is replaced by its two's complement, and this is applied after half selection.
- R4: The result is computed as: select the halves, apply negation, add A and B, apply the optional shift to that sum, then add C.
- R5: The 2-bit shift field at bits [38:37] acts on the A+B sum. Code 0 leaves it unchanged, code 1 is a logical right shift by 16, and code 2 is a logical left shift by 16.
- R6: Code 3 in any half field acts as code 0, and code 3 in the shift field acts as no shift.
- R7: Every addition wraps modulo 2^32.
- R8: If bit 47 or bit 48 is set, the unsupported flag is high with the valid pulse and the write enable is low. The result data is still computed normally.
- R9: Valid, result, destination index, write enable and unsupported flag all appear one clock after the issue strobe. Synchronous reset clears valid, write enable, the flag, the result and the destination index.
- R10: In a cycle that follows no issue, valid, write enable and the unsupported flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issueStb | input | 1 | Instruction issue strobe |
| instrWord | input | 64 | Instruction word |
| opA | input | 32 | Operand A from the register file port |
| opB | input | 32 | Operand B, pre-fetched |
| opC | input | 32 | Operand C, pre-fetched |
| srcAIdx | output | 8 | Register index for the operand A read port |
| resValid | output | 1 | Result valid pulse |
| resData | output | 32 | Result value |
| resDstIdx | output | 8 | Destination register index |
| resWrEn | output | 1 | Register write enable |
| resUnsupported | output | 1 | Unsupported encoding flag |

## Verification
Two functions can fall in the same cycle: flagging an unsupported encoding and computing a full result with negation and a shift. The bench issues words that set bit 47 or bit 48 together with negated upper-half operands and a shift. It expects the flag high, the write enable low and the data equal to the reference value. A second overlap is an issue in the cycle its predecessor's result emerges. Back-to-back issues are judged one cycle apart: each must show its own value and index, and the cycle after the last issue must show no valid pulse.

// File: rtl/tri_add_pkg.sv
`timescale 1ns/1ps
package tri_add_pkg;
  localparam int INSN_W = 64;
  localparam int REG_W  = 8;

  // instruction field positions
  localparam int DST_LSB    = 0;
  localparam int SRCA_LSB   = 8;
  localparam int HALF_C_LSB = 31;
  localparam int HALF_B_LSB = 33;
  localparam int HALF_A_LSB = 35;
  localparam int SHIFT_LSB  = 37;
  localparam int CC_BIT     = 47;
  localparam int EXT_BIT    = 48;
  localparam int NEG_C_BIT  = 49;
  localparam int NEG_B_BIT  = 50;
  localparam int NEG_A_BIT  = 51;

  typedef enum logic [1:0] {
    HALF_ALL = 2'd0,
    HALF_LO  = 2'd1,
    HALF_HI  = 2'd2,
    HALF_RSV = 2'd3
  } halfSel_e;

  typedef enum logic [1:0] {
    SHIFT_NONE  = 2'd0,
    SHIFT_RIGHT = 2'd1,
    SHIFT_LEFT  = 2'd2,
    SHIFT_RSV   = 2'd3
  } shiftSel_e;

  // strobes from control to datapath; negMask bit 0 = A, 1 = B, 2 = C
  typedef struct packed {
    logic             capture;
    logic             writeOk;
    logic             unsupported;
    halfSel_e         halfA;
    halfSel_e         halfB;
    halfSel_e         halfC;
    logic [2:0]       negMask;
    shiftSel_e        shiftSel;
    logic [REG_W-1:0] dstIdx;
  } ctrlStrobes_t;
endpackage

// File: rtl/tri_add_ctrl.sv
`timescale 1ns/1ps
module tri_add_ctrl
  import tri_add_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              issueStb,
  input  logic [INSN_W-1:0] instrWord,
  output ctrlStrobes_t      ctrl,
  output logic [REG_W-1:0]  srcAIdx
);

  function automatic halfSel_e normHalf(input logic [1:0] code);
    return (code == 2'd3) ? HALF_ALL : halfSel_e'(code);
  endfunction

  function automatic shiftSel_e normShift(input logic [1:0] code);
    return (code == 2'd3) ? SHIFT_NONE : shiftSel_e'(code);
  endfunction

  logic unsupportedBits;
  assign unsupportedBits = instrWord[CC_BIT] | instrWord[EXT_BIT];
  assign srcAIdx = instrWord[SRCA_LSB +: REG_W];

  always_comb begin
    ctrl             = '0;
    ctrl.capture     = issueStb;
    ctrl.unsupported = unsupportedBits;
    ctrl.writeOk     = ~unsupportedBits;
    ctrl.halfA       = normHalf(instrWord[HALF_A_LSB +: 2]);
    ctrl.halfB       = normHalf(instrWord[HALF_B_LSB +: 2]);
    ctrl.halfC       = normHalf(instrWord[HALF_C_LSB +: 2]);
    ctrl.negMask     = {instrWord[NEG_C_BIT], instrWord[NEG_B_BIT], instrWord[NEG_A_BIT]};
    ctrl.shiftSel    = normShift(instrWord[SHIFT_LSB +: 2]);
    ctrl.dstIdx      = instrWord[DST_LSB +: REG_W];
  end

  AST_UNSUP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    ctrl.unsupported |-> !ctrl.writeOk); // R8

  AST_NO_RSV_CODES: assert property (@(posedge clk) disable iff (rst)
    (ctrl.halfA != HALF_RSV) && (ctrl.halfB != HALF_RSV) && (ctrl.halfC != HALF_RSV)
    && (ctrl.shiftSel != SHIFT_RSV)); // R6

endmodule

// File: rtl/tri_add_dp.sv
`timescale 1ns/1ps
module tri_add_dp
  import tri_add_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opC,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  output logic [REG_W-1:0]  resDstIdx,
  output logic              resWrEn,
  output logic              resUnsupported
);
  localparam int HALF_W  = DATA_W / 2;
  localparam int NUM_OPS = 3;

  logic     [NUM_OPS-1:0][DATA_W-1:0] rawOp;
  logic     [NUM_OPS-1:0][DATA_W-1:0] condOp;
  halfSel_e [NUM_OPS-1:0]             halfOf;

  assign rawOp[0]  = opA;
  assign rawOp[1]  = opB;
  assign rawOp[2]  = opC;
  assign halfOf[0] = ctrl.halfA;
  assign halfOf[1] = ctrl.halfB;
  assign halfOf[2] = ctrl.halfC;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_operand
    logic [DATA_W-1:0] selVal;
    always_comb begin
      case (halfOf[g])
        HALF_LO: selVal = {{(DATA_W-HALF_W){1'b0}}, rawOp[g][HALF_W-1:0]};
        HALF_HI: selVal = {{HALF_W{1'b0}}, rawOp[g][DATA_W-1:HALF_W]};
        default: selVal = rawOp[g];
      endcase
    end
    assign condOp[g] = ctrl.negMask[g] ? ({DATA_W{1'b0}} - selVal) : selVal;

    AST_HALF_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
      (halfOf[g] != HALF_ALL) |-> (selVal[DATA_W-1:HALF_W] == '0)); // R2
  end

  logic [DATA_W-1:0] abSum;
  logic [DATA_W-1:0] abShift;
  logic [DATA_W-1:0] total;

  assign abSum = condOp[0] + condOp[1];

  always_comb begin
    case (ctrl.shiftSel)
      SHIFT_RIGHT: abShift = abSum >> HALF_W;
      SHIFT_LEFT:  abShift = abSum << HALF_W;
      default:     abShift = abSum;
    endcase
  end

  assign total = abShift + condOp[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid       <= 1'b0;
      resWrEn        <= 1'b0;
      resUnsupported <= 1'b0;
      resData        <= '0;
      resDstIdx      <= '0;
    end else begin
      resValid       <= ctrl.capture;
      resWrEn        <= ctrl.capture & ctrl.writeOk;
      resUnsupported <= ctrl.capture & ctrl.unsupported;
      if (ctrl.capture) begin
        resData   <= total;
        resDstIdx <= ctrl.dstIdx;
      end
    end
  end

  AST_VALID_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
    ctrl.capture |=> resValid); // R9
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !ctrl.capture |=> (!resValid && !resWrEn && !resUnsupported)); // R10
  AST_WREN_GATED: assert property (@(posedge clk) disable iff (rst)
    resWrEn |-> (resValid && !resUnsupported)); // R8
  AST_DST_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ctrl.capture |=> (resDstIdx == $past(ctrl.dstIdx))); // R1
  AST_SHR_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ctrl.shiftSel == SHIFT_RIGHT) |-> (abShift[DATA_W-1:HALF_W] == '0)); // R5
  AST_SHL_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ctrl.shiftSel == SHIFT_LEFT) |-> (abShift[HALF_W-1:0] == '0)); // R5

endmodule

// File: rtl/tri_add_unit.sv
`timescale 1ns/1ps
module tri_add_unit
  import tri_add_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issueStb,
  input  logic [INSN_W-1:0] instrWord,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opC,
  output logic [REG_W-1:0]  srcAIdx,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  output logic [REG_W-1:0]  resDstIdx,
  output logic              resWrEn,
  output logic              resUnsupported
);

  ctrlStrobes_t ctrl;

  tri_add_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .issueStb  (issueStb),
    .instrWord (instrWord),
    .ctrl      (ctrl),
    .srcAIdx   (srcAIdx)
  );

  tri_add_dp #(.DATA_W(DATA_W)) dp_i (
    .clk            (clk),
    .rst            (rst),
    .ctrl           (ctrl),
    .opA            (opA),
    .opB            (opB),
    .opC            (opC),
    .resValid       (resValid),
    .resData        (resData),
    .resDstIdx      (resDstIdx),
    .resWrEn        (resWrEn),
    .resUnsupported (resUnsupported)
  );

endmodule

// File: tb/tri_add_unit_tb_top.sv
`timescale 1ns/1ps
module tri_add_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issueStb = 1'b0;
  logic [63:0] instrWord = '0;
  logic [31:0] opA = '0, opB = '0, opC = '0;
  logic [7:0]  srcAIdx;
  logic        resValid;
  logic [31:0] resData;
  logic [7:0]  resDstIdx;
  logic        resWrEn;
  logic        resUnsupported;

  int checkCnt = 0;
  int failCnt  = 0;
  bit doneFlag = 1'b0;

  always #2.5 clk = ~clk;

  tri_add_unit dut_i (
    .clk(clk), .rst(rst), .issueStb(issueStb), .instrWord(instrWord),
    .opA(opA), .opB(opB), .opC(opC), .srcAIdx(srcAIdx),
    .resValid(resValid), .resData(resData), .resDstIdx(resDstIdx),
    .resWrEn(resWrEn), .resUnsupported(resUnsupported)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkWord(input logic [7:0] dst, input logic [7:0] sa,
      input logic [1:0] ha, input logic [1:0] hb, input logic [1:0] hc, input logic [1:0] sh,
      input bit na, input bit nb, input bit nc, input bit cc, input bit xb);
    logic [63:0] w = '0;
    w[7:0] = dst; w[15:8] = sa; w[32:31] = hc; w[34:33] = hb; w[36:35] = ha;
    w[38:37] = sh; w[47] = cc; w[48] = xb; w[49] = nc; w[50] = nb; w[51] = na;
    return w;
  endfunction

  function automatic logic [31:0] pickHalf(input logic [31:0] v, input logic [1:0] code);
    if (code == 2'd1) return {16'h0, v[15:0]};
    if (code == 2'd2) return {16'h0, v[31:16]};
    return v;
  endfunction

  function automatic logic [31:0] refModel(input logic [63:0] w, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] c);
    logic [31:0] x, y, z, s;
    x = pickHalf(a, w[36:35]); y = pickHalf(b, w[34:33]); z = pickHalf(c, w[32:31]);
    if (w[51]) x = 32'd0 - x;
    if (w[50]) y = 32'd0 - y;
    if (w[49]) z = 32'd0 - z;
    s = x + y;
    if (w[38:37] == 2'd1) s = s >> 16;
    else if (w[38:37] == 2'd2) s = s << 16;
    return s + z;
  endfunction

  // issue one word and check the registered result one clock later
  task automatic runOne(input logic [63:0] w, input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] c, input string req);
    logic [31:0] expVal;
    bit unsup;
    expVal = refModel(w, a, b, c);
    unsup = w[47] | w[48];
    @(negedge clk);
    issueStb = 1'b1; instrWord = w; opA = a; opB = b; opC = c;
    #1;
    chk(srcAIdx == w[15:8], "R1 srcAIdx", srcAIdx, w[15:8]);
    @(negedge clk);
    issueStb = 1'b0;
    chk(resValid == 1'b1, "R9 valid", resValid, 1);
    chk(resData == expVal, req, resData, expVal);
    chk(resDstIdx == w[7:0], "R1 dst", resDstIdx, w[7:0]);
    chk(resWrEn == !unsup, "R8 wrEn", resWrEn, !unsup);
    chk(resUnsupported == unsup, "R8 flag", resUnsupported, unsup);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(resValid == 0, "R9 reset valid", resValid, 0);
    chk(resWrEn == 0, "R9 reset wrEn", resWrEn, 0);
    chk(resUnsupported == 0, "R9 reset flag", resUnsupported, 0);
    chk(resData == 0, "R9 reset data", resData, 0);
    chk(resDstIdx == 0, "R9 reset dst", resDstIdx, 0);
  endtask

  task automatic testHalves();
    runOne(mkWord(8'h11, 8'h22, 2'd1, 2'd0, 2'd0, 2'd0, 0,0,0,0,0), 32'h1234ABCD, 0, 0, "R2 A low");
    chk(resData == 32'h0000ABCD, "R2 A low fixed", resData, 32'h0000ABCD);
    runOne(mkWord(8'h12, 8'h23, 2'd0, 2'd2, 2'd0, 2'd0, 0,0,0,0,0), 0, 32'h1234ABCD, 0, "R2 B high");
    chk(resData == 32'h00001234, "R2 B high fixed", resData, 32'h00001234);
    runOne(mkWord(8'h13, 8'h24, 2'd0, 2'd0, 2'd2, 2'd0, 0,0,0,0,0), 5, 6, 32'hFFFF0000, "R2 C high");
  endtask

  task automatic testNegate();
    runOne(mkWord(8'h30, 8'h31, 2'd2, 2'd0, 2'd0, 2'd0, 1,0,0,0,0), 32'h80001234, 0, 0, "R3 neg A high");
    chk(resData == 32'hFFFF8000, "R3 neg A high fixed", resData, 32'hFFFF8000);
    runOne(mkWord(8'h32, 8'h33, 2'd0, 2'd1, 2'd0, 2'd0, 0,1,1,0,0), 100, 32'hAAAA0007, 3, "R3 neg B C");
    chk(resData == 32'd90, "R3 neg B C fixed", resData, 32'd90);
  endtask

  task automatic testShift();
    runOne(mkWord(8'h40, 8'h41, 2'd0, 2'd0, 2'd0, 2'd2, 0,0,0,0,0), 32'h00010002, 32'h00030004, 32'h5, "R5 left");
    chk(resData == 32'h00060005, "R5 left fixed", resData, 32'h00060005);
    runOne(mkWord(8'h42, 8'h43, 2'd0, 2'd0, 2'd0, 2'd1, 0,0,0,0,0), 32'h00010000, 32'h00010000, 32'h00010000, "R4 right order");
    chk(resData == 32'h00010002, "R4 shift excludes C", resData, 32'h00010002);
  endtask

  task automatic testReserved();
    runOne(mkWord(8'h50, 8'h51, 2'd3, 2'd3, 2'd3, 2'd3, 0,0,0,0,0), 32'h12340000, 32'h00005678, 32'h10000000, "R6 reserved codes");
    chk(resData == 32'h22345678, "R6 reserved fixed", resData, 32'h22345678);
  endtask

  task automatic testWrap();
    runOne(mkWord(8'h60, 8'h61, 2'd0, 2'd0, 2'd0, 2'd0, 0,0,0,0,0), 32'hFFFFFFFF, 32'h2, 32'hFFFFFFFF, "R7 wrap");
    chk(resData == 32'h0, "R7 wrap fixed", resData, 32'h0);
  endtask

  task automatic testUnsupported();
    runOne(mkWord(8'h70, 8'h71, 2'd2, 2'd1, 2'd0, 2'd2, 1,0,1,1,0), 32'hC0DE0000, 32'h1111BEEF, 9, "R8 cc with datapath");
    runOne(mkWord(8'h72, 8'h73, 2'd0, 2'd2, 2'd1, 2'd1, 0,1,0,0,1), 32'h77, 32'h9ABC0000, 32'h5, "R8 ext with datapath");
  endtask

  task automatic testBackToBack();
    logic [63:0] w1, w2;
    w1 = mkWord(8'h81, 8'h01, 2'd0, 2'd0, 2'd0, 2'd0, 0,0,0,0,0);
    w2 = mkWord(8'h82, 8'h02, 2'd1, 2'd0, 2'd0, 2'd2, 0,1,0,0,0);
    @(negedge clk);
    issueStb = 1; instrWord = w1; opA = 1; opB = 2; opC = 3;
    @(negedge clk);
    chk(resData == 32'd6 && resDstIdx == 8'h81, "R9 b2b first", resData, 6);
    instrWord = w2; opA = 32'hFFFF0004; opB = 1; opC = 0;
    @(negedge clk);
    issueStb = 0;
    chk(resValid && resData == 32'h00030000 && resDstIdx == 8'h82, "R9 b2b second", resData, 32'h00030000);
    @(negedge clk);
    chk(!resValid && !resWrEn && !resUnsupported, "R10 idle after", {resValid, resWrEn, resUnsupported}, 0);
    chk(resData == 32'h00030000, "R10 data held", resData, 32'h00030000);
  endtask

  task automatic testRandom();
    for (int i = 0; i < 200; i++) begin
      logic [63:0] w;
      w = {$urandom, $urandom};
      if (i % 4 != 0) begin w[47] = 0; w[48] = 0; end
      runOne(w, $urandom, $urandom, $urandom, "R4 random");
    end
  endtask

  task automatic testResetMid();
    @(negedge clk);
    issueStb = 1; instrWord = mkWord(8'h90, 0, 0,0,0,0, 0,0,0,0,0); opA = 7;
    @(negedge clk);
    issueStb = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    chk(!resValid && !resWrEn && resData == 0, "R9 reset clears", {resValid, resWrEn}, 0);
  endtask

  task automatic finishUp();
    $display("  %0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    testReset();
    testHalves();
    testNegate();
    testShift();
    testReserved();
    testWrap();
    testUnsupported();
    testBackToBack();
    testRandom();
    testResetMid();
    doneFlag = 1;
    finishUp();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      finishUp();
    end
  end
endmodule